// File: doc/BRIEF.md
# Shift-Based Exponential Unit

This unit approximates e raised to a non-positive fixed-point number without a multiplier or a lookup table. The caller gives the input as an unsigned magnitude `m`, so the value being exponentiated is y = -m / 2^IN_FRAC. This is the form a softmax datapath has after it subtracts the row maximum. The magnitude is scaled by log2(e) with a shift-and-add constant multiplier (1.0111 in binary), giving a fixed-point value S. S is split into a right-shift count and a fractional remainder v. The remainder is turned into a mantissa by adding a bias, which is a linear fit of 2^v. The mantissa is then shifted right by the count.

One mode bit picks between two passes. The accumulation pass exponentiates the magnitude on its own, and the log-sum operand has no effect. The normalisation pass first adds a supplied non-negative log-sum value to the magnitude, which subtracts it from y, and uses a second bias constant. Each valid input gives one registered result on the next cycle.

Top module: `shift_exp_unit`

## Requirements
- R1: While reset is held low, and after it is released with no valid input, `outValid` is 0 and `expOut` is 0.
- R2: `outValid` is high in exactly the cycle after each cycle in which `inValid` was high, and `expOut` carries the result of that input in the same cycle.
- R3: With `modeSel` = 0 (accumulation pass), the total magnitude is `magIn` alone, and `lnSum` has no effect on the result.
- R4: The scaled value is S = 23 · T, counted in units of 2^-(IN_FRAC+4), where T is the total magnitude. This is T multiplied by binary 1.0111, formed as T + T/2 - T/16.
- R5: The right-shift count is r = ceil(S / 2^(IN_FRAC+4)). The fraction is v = (2^(IN_FRAC+4) - (S mod 2^(IN_FRAC+4))) mod 2^(IN_FRAC+4), aligned to OUT_FRAC bits.
- R6: The mantissa is v plus a bias: BIAS_SUM in the accumulation pass and BIAS_NORM in the normalisation pass, both in units of 2^-OUT_FRAC. A zero total magnitude returns the bias itself.
- R7: With `modeSel` = 1 (normalisation pass), the total magnitude is `magIn` + `lnSum`. Both share IN_FRAC fraction bits.
- R8: When r is greater than or equal to OUT_W (OUT_FRAC+1), the result is exactly 0. Below that, the result is the mantissa shifted right by r.
- R9: `expOut` never exceeds 1.0, which is 2^OUT_FRAC.
- R10: In a cycle without a valid input, `expOut` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Qualifies `magIn`, `lnSum` and `modeSel` |
| modeSel | input | 1 | 0 = accumulation pass, 1 = normalisation pass |
| magIn | input | IN_INT+IN_FRAC | Magnitude of the non-positive input, IN_FRAC fraction bits |
| lnSum | input | LN_INT+IN_FRAC | Non-negative log-sum operand, IN_FRAC fraction bits |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| expOut | output | OUT_FRAC+1 | Approximated exponential, OUT_FRAC fraction bits |

## Verification
Two things can happen in the same cycle: the register presents the result of one pass while the next input, captured with the other mode and bias, is already being computed. The bench provokes this with back-to-back valid inputs whose mode alternates every cycle. It checks that every result carries its own pass's bias and log-sum handling and does not pick up those of its neighbour. The saturation path and the bias path can also meet at the boundary shift counts. Magnitudes that land on the last non-zero shift and on the first saturating shift are placed next to each other, and each is compared against the bench's own integer model.

// File: rtl/sexp_pkg.sv
package sexp_pkg;

  typedef enum logic {
    PASS_SUM  = 1'b0,
    PASS_NORM = 1'b1
  } pass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // capture a new result this cycle
    logic addLog;      // add the log-sum operand to the magnitude
    logic useNormBias; // select the normalisation-pass bias
  } dp_strobe_t;

endpackage

// File: rtl/sexp_log2e_scaler.sv
// Multiplies a magnitude by binary 1.0111 (~log2 e) with one 3:2 carry-save
// row and a single carry-propagate adder. The output carries four extra
// fraction bits so the product is exact.
module sexp_log2e_scaler #(
  parameter int MAG_W = 9,
  parameter int SCL_W = MAG_W + 5
) (
  input  logic [MAG_W-1:0] magIn,
  output logic [SCL_W-1:0] scaled
);

  logic [SCL_W-1:0] opA, opB, opC, sumV, carV;

  always_comb begin
    opA  = SCL_W'({magIn, 4'b0000});
    opB  = opA >> 1;
    opC  = ~(opA >> 4);        // two's complement of A/16 minus one
    sumV = opA ^ opB ^ opC;
    carV = ((opA & opB) | (opA & opC) | (opB & opC)) << 1;
    scaled = sumV + carV + SCL_W'(1);
  end

  // R4
  always_comb begin
    if (!$isunknown(magIn)) begin
      scale_match_chk: assert (scaled == SCL_W'(opA + opB - (opA >> 4)))
        else $error("carry-save scaling mismatch");
    end
  end

endmodule

// File: rtl/sexp_ctrl.sv
module sexp_ctrl
  import sexp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       modeSel,
  output dp_strobe_t strobe,
  output logic       outValid
);

  pass_e passNow;

  always_comb begin
    passNow            = pass_e'(modeSel);
    strobe.load        = inValid;
    strobe.addLog      = inValid && (passNow == PASS_NORM);
    strobe.useNormBias = (passNow == PASS_NORM);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/sexp_datapath.sv
module sexp_datapath
  import sexp_pkg::*;
#(
  parameter int IN_W      = 8,
  parameter int LN_W      = 8,
  parameter int IN_FRAC   = 4,
  parameter int OUT_FRAC  = 8,
  parameter int BIAS_SUM  = 245,
  parameter int BIAS_NORM = 248
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_strobe_t          strobe,
  input  logic [IN_W-1:0]     magIn,
  input  logic [LN_W-1:0]     lnSum,
  output logic [OUT_FRAC:0]   expOut
);

  localparam int OUT_W  = OUT_FRAC + 1;
  localparam int MAG_W  = ((IN_W > LN_W) ? IN_W : LN_W) + 1;
  localparam int SCL_W  = MAG_W + 5;
  localparam int FR_W   = IN_FRAC + 4;
  localparam int INT_W  = SCL_W - FR_W;
  localparam int SH_W   = INT_W + 1;
  localparam int STG    = $clog2(OUT_W);
  localparam int PAD_W  = (SH_W > STG) ? SH_W : STG;
  localparam int MNT_W  = OUT_FRAC + 2;
  localparam logic [MNT_W-1:0] BIAS_S = MNT_W'(BIAS_SUM);
  localparam logic [MNT_W-1:0] BIAS_N = MNT_W'(BIAS_NORM);
  localparam logic [OUT_W-1:0] ONE    = OUT_W'(1) << OUT_FRAC;

  logic [MAG_W-1:0]    magTotal;
  logic [SCL_W-1:0]    scaled;
  logic [INT_W-1:0]    sInt;
  logic [FR_W-1:0]     sFrac, vFrac;
  logic [SH_W-1:0]     shiftAmt;
  logic [PAD_W-1:0]    shPad;
  logic [OUT_FRAC-1:0] vAl;
  logic [MNT_W-1:0]    mant;
  logic [MNT_W-1:0]    stg [0:STG];
  logic                sat;
  logic [OUT_W-1:0]    nextOut;

  // pass 2 subtracts the log-sum from y, i.e. adds it to the magnitude
  always_comb begin
    magTotal = MAG_W'(magIn);
    if (strobe.addLog) magTotal = magTotal + MAG_W'(lnSum);
  end

  sexp_log2e_scaler #(.MAG_W(MAG_W), .SCL_W(SCL_W)) u_scale (
    .magIn  (magTotal),
    .scaled (scaled)
  );

  // y*log2e = -S: u = floor(-S) = -ceil(S), v = -S - u
  always_comb begin
    sInt     = scaled[SCL_W-1:FR_W];
    sFrac    = scaled[FR_W-1:0];
    vFrac    = -sFrac;
    shiftAmt = SH_W'(sInt) + SH_W'(|sFrac);
    shPad    = PAD_W'(shiftAmt);
  end

  generate
    if (FR_W >= OUT_FRAC) begin : g_trunc
      assign vAl = OUT_FRAC'(vFrac >> (FR_W - OUT_FRAC));
    end else begin : g_widen
      assign vAl = {vFrac, {(OUT_FRAC - FR_W){1'b0}}};
    end
  endgenerate

  // linear fit of 2^v with a pass-dependent bias
  always_comb begin
    mant = MNT_W'(vAl) + (strobe.useNormBias ? BIAS_N : BIAS_S);
  end

  // logarithmic right shifter
  assign stg[0] = mant;
  generate
    for (genvar k = 0; k < STG; k++) begin : g_shift
      assign stg[k+1] = shPad[k] ? (stg[k] >> (2**k)) : stg[k];
    end
  endgenerate

  always_comb begin
    sat     = (shPad >= PAD_W'(OUT_W));
    nextOut = sat ? '0 : OUT_W'(stg[STG]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            expOut <= '0;
    else if (strobe.load) expOut <= nextOut;
  end

  // R9
  out_le_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    expOut <= ONE);
  // R8
  sat_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && (shiftAmt >= SH_W'(OUT_W))) |=> (expOut == '0));
  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(expOut));
  // R6
  zero_bias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.useNormBias && (magTotal == '0))
      |=> (expOut == OUT_W'(BIAS_SUM)));

endmodule

// File: rtl/shift_exp_unit.sv
module shift_exp_unit
  import sexp_pkg::*;
#(
  parameter int IN_INT    = 4,
  parameter int IN_FRAC   = 4,
  parameter int LN_INT    = 4,
  parameter int OUT_FRAC  = 8,
  parameter int BIAS_SUM  = 245,
  parameter int BIAS_NORM = 248,
  localparam int IN_W     = IN_INT + IN_FRAC,
  localparam int LN_W     = LN_INT + IN_FRAC,
  localparam int OUT_W    = OUT_FRAC + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             modeSel,
  input  logic [IN_W-1:0]  magIn,
  input  logic [LN_W-1:0]  lnSum,
  output logic             outValid,
  output logic [OUT_W-1:0] expOut
);

  dp_strobe_t strobe;

  sexp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .modeSel  (modeSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  sexp_datapath #(
    .IN_W      (IN_W),
    .LN_W      (LN_W),
    .IN_FRAC   (IN_FRAC),
    .OUT_FRAC  (OUT_FRAC),
    .BIAS_SUM  (BIAS_SUM),
    .BIAS_NORM (BIAS_NORM)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .magIn  (magIn),
    .lnSum  (lnSum),
    .expOut (expOut)
  );

endmodule

// File: tb/sim_shift_exp_unit.sv
module sim_shift_exp_unit;

  typedef struct {
    int    val;
    string tag;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       modeSel = 1'b0;
  logic [7:0] magIn = '0;
  logic [7:0] lnSum = '0;
  logic       outValid;
  logic [8:0] expOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  exp_item_t expQ[$];

  always #10 clk = ~clk;   // 50 MHz

  shift_exp_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeSel(modeSel),
    .magIn(magIn), .lnSum(lnSum), .outValid(outValid), .expOut(expOut)
  );

  // independent integer model of the requirements (default parameters)
  function automatic int model(int m, int ln, int mode);
    int t, s, r, v, mant;
    t = (mode == 1) ? m + ln : m;            // R3, R7
    s = 23 * t;                              // R4
    r = (s + 255) / 256;                     // R5
    v = (256 - (s % 256)) % 256;
    mant = v + ((mode == 1) ? 248 : 245);    // R6
    if (r >= 9) return 0;                    // R8
    return mant >> r;
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic drive(int m, int ln, int mode, string tag);
    exp_item_t it;
    @(negedge clk);
    inValid = 1'b1; magIn = 8'(m); lnSum = 8'(ln); modeSel = mode[0];
    it.val = model(m, ln, mode); it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; magIn = 8'hA5; lnSum = 8'h5A; modeSel = ~modeSel;
    end
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected outValid", 1, 0);
      end else begin
        exp_item_t it;
        it = expQ.pop_front();
        check(it.tag, int'(expOut), it.val);
        check("R9 <= 1.0", int'(expOut <= 9'd256), 1);
      end
    end
  end

  initial begin
    int last;
    repeat (3) @(negedge clk);
    check("R1 reset outValid", int'(outValid), 0);
    check("R1 reset expOut", int'(expOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(outValid), 0);

    drive(0, 0, 0, "R6 zero magnitude pass1");
    drive(16, 0, 0, "R4 R5 m=1.0 pass1");
    drive(16, 200, 0, "R3 lnSum ignored pass1");
    drive(8, 77, 0, "R5 m=0.5 pass1");
    drive(1, 0, 0, "R5 smallest step");
    drive(0, 0, 1, "R6 zero magnitude pass2");
    drive(10, 6, 1, "R7 magnitude plus log-sum");
    // alternating modes back to back
    drive(5, 3, 0, "R3 alternate pass1");
    drive(5, 3, 1, "R7 alternate pass2");
    drive(40, 0, 0, "R3 alternate pass1 b");
    drive(20, 20, 1, "R7 alternate pass2 b");
    // saturation boundary
    drive(80, 0, 0, "R8 last non-zero shift");
    drive(90, 0, 0, "R8 first saturating shift");
    drive(255, 255, 1, "R8 largest magnitude");
    drive(3, 1, 1, "R6 after saturation");
    idle(1);
    @(negedge clk);
    last = int'(expOut);
    check("R2 outValid low when idle", int'(outValid), 0);
    idle(3);
    check("R10 hold value", int'(expOut), model(3, 1, 1));
    check("R10 hold stable", int'(expOut), last);
    check("R2 all results delivered", expQ.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule